// File: doc/BRIEF.md
# Cascaded Encoded Interrupt Controller

The block collects interrupt requests from three tiers (critical, main and peripheral) and a 32-source DMA pending register that sits under the peripheral tier. Each tier picks one winner, and the block packs the critical, main and peripheral winners into one encoded status word. A consumer reads that word and tests the critical flag first, then the main flag, then the peripheral flag.

Reserved entries link the tiers. Main entry 4 does not name a leaf source: it is active when the peripheral tier has a winner. Peripheral entry 0 is active when the DMA tier has a winner. The DMA winner comes out on its own pair of ports. Critical entry 2 is the line that the system wires to its high-priority peripheral request. The critical tier has no mask.

A synchronous register port holds the three mask registers and the DMA pending register, which is cleared by writing ones. The same port returns the status word on read. Within a tier all priorities are equal, and the lowest-numbered active entry wins.

Top module: `cascade_intc`

## Requirements
- R1: After reset, the registers read as follows. Main mask 0x00010FFF, peripheral mask 0x7FFFFC00, DMA mask 0xFFFFFFFF, DMA pending 0x00000000, and status 0x00000000 while no request is active.
- R2: The register addresses are fixed. 0 is the main mask (17 bits, upper read bits zero), 1 the peripheral mask, 2 the DMA mask, 3 the DMA pending register and 4 the status word. A write lands on the clock edge where reg_we is high, and reads are combinational.
- R3: In every mask register, a bit at 1 disables its source and a bit at 0 enables it.
- R4: Main entry n (0 to 16) is controlled by main mask bit 16-n.
- R5: Peripheral entry n (0 to 31) is controlled by peripheral mask bit 31-n.
- R6: Pending bit n is set on a rising edge of dma_req[n] (low in one sampled cycle, high in the next). A request held high does not set the bit again after it is cleared.
- R7: A write to address 3 clears each pending bit whose write-data bit is 1, and leaves each bit whose write-data bit is 0 unchanged. A write to address 4 changes nothing.
- R8: If a pending bit sees a rising edge and a write-one-to-clear in the same cycle, it ends set.
- R9: Status bit 10 flags a critical winner, and bits 9:8 hold its number, taken from crit_req.
- R10: Status bit 21 flags a main winner, and bits 20:16 hold its number. Entry 4 is driven by the peripheral tier's flag, and main_req[4] is ignored.
- R11: Status bit 29 flags a peripheral winner, and bits 28:24 hold its number. Entry 0 is driven by the DMA flag, and per_req[0] is ignored. dma_valid and dma_num report the lowest set bit of pending AND NOT DMA mask.
- R12: Within each tier, the lowest-numbered active entry wins. With no active entry, the tier's flag and number are zero.
- R13: A read of address 4 returns the same value as the enc_status port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crit_req | input | 4 | Critical-tier level requests |
| main_req | input | 17 | Main-tier level requests |
| per_req | input | 32 | Peripheral-tier level requests |
| dma_req | input | 32 | DMA event lines, edge-latched |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| enc_status | output | 32 | Encoded winner status word |
| dma_valid | output | 1 | DMA tier has an unmasked pending source |
| dma_num | output | 5 | Lowest unmasked pending DMA source |

## Verification
A rising DMA request and a write-one-to-clear can hit the same pending bit in the same cycle. The bench provokes this by holding dma_req[3] low, then raising it on the same edge that commits a write of 0x8 to the pending register. It judges the outcome by reading back the pending register and the DMA winner, which must both show bit 3 still set. A second collision occurs when all three tiers are active together. Here every flag and number in the status word is compared against a value worked out by hand.

// File: rtl/cascade_intc.sv
module cascade_intc #(
  parameter int NMAIN = 17,
  parameter int NW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      crit_req,
  input  logic [NMAIN-1:0] main_req,
  input  logic [NW-1:0]   per_req,
  input  logic [NW-1:0]   dma_req,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [NW-1:0]   reg_wdata,
  output logic [NW-1:0]   reg_rdata,
  output logic [NW-1:0]   enc_status,
  output logic            dma_valid,
  output logic [4:0]      dma_num
);
  localparam logic [2:0] A_MAIN = 3'd0, A_PER = 3'd1, A_DMSK = 3'd2,
                         A_PEND = 3'd3, A_STAT = 3'd4;
  localparam logic [NMAIN-1:0] MAIN_RST = NMAIN'(32'h0001_0FFF);
  localparam logic [NW-1:0]    PER_RST  = 32'h7FFF_FC00;

  logic [NMAIN-1:0] main_mask;
  logic [NW-1:0] per_mask, dma_mask, dma_pend, dma_prev;
  logic [NMAIN-1:0] main_act;
  logic [NW-1:0] per_act;
  logic crit_v, main_v, per_v;
  logic [4:0] crit_n, main_n, per_n;

  function automatic logic [5:0] lowest(input logic [NW-1:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = NW-1; i >= 0; i--)
      if (v[i]) r = {1'b1, 5'(i)};
    return r;
  endfunction

  wire [NW-1:0] dma_rise = dma_req & ~dma_prev;
  wire          wr_pend  = reg_we && reg_addr == A_PEND;
  wire [NW-1:0] clr_bits = wr_pend ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_mask <= MAIN_RST;
      per_mask  <= PER_RST;
      dma_mask  <= '1;
      dma_pend  <= '0;
      dma_prev  <= '1;
    end else begin
      dma_prev <= dma_req;
      dma_pend <= (dma_pend & ~clr_bits) | dma_rise;
      if (reg_we && reg_addr == A_MAIN) main_mask <= reg_wdata[NMAIN-1:0];
      if (reg_we && reg_addr == A_PER)  per_mask  <= reg_wdata;
      if (reg_we && reg_addr == A_DMSK) dma_mask  <= reg_wdata;
    end
  end

  assign {dma_valid, dma_num} = lowest(dma_pend & ~dma_mask);

  always_comb begin
    for (int n = 0; n < NW; n++)
      per_act[n] = ((n == 0) ? dma_valid : per_req[n]) & ~per_mask[NW-1-n];
    {per_v, per_n} = lowest(per_act);
    for (int n = 0; n < NMAIN; n++)
      main_act[n] = ((n == 4) ? per_v : main_req[n]) & ~main_mask[NMAIN-1-n];
    {main_v, main_n} = lowest(NW'(main_act));
    {crit_v, crit_n} = lowest(NW'(crit_req));
  end

  assign enc_status = {2'b00, per_v, per_n, 2'b00, main_v, main_n,
                       5'b0, crit_v, crit_n[1:0], 8'b0};

  always_comb begin
    case (reg_addr)
      A_MAIN:  reg_rdata = NW'(main_mask);
      A_PER:   reg_rdata = per_mask;
      A_DMSK:  reg_rdata = dma_mask;
      A_PEND:  reg_rdata = dma_pend;
      A_STAT:  reg_rdata = enc_status;
      default: reg_rdata = '0;
    endcase
  end

  a_r8_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dma_rise) != '0 |-> (dma_pend & $past(dma_rise)) == $past(dma_rise));
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_pend) |-> (dma_pend & $past(reg_wdata) & ~$past(dma_rise)) == '0);
  a_r11_dma_winner: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid |-> dma_pend[dma_num] && !dma_mask[dma_num]);
  a_r9_crit_source: assert property (@(posedge clk) disable iff (!rst_n)
    enc_status[10] |-> crit_req[enc_status[9:8]]);
  a_r4_main_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    enc_status[21] |-> !main_mask[NMAIN-1-int'(enc_status[20:16])]);
  a_r5_per_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    enc_status[29] |-> !per_mask[NW-1-int'(enc_status[28:24])]);
  a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we && reg_addr == A_MAIN) |-> $stable(main_mask));
endmodule

// File: tb/cascade_intc_tb.sv
module cascade_intc_tb;
  logic clk = 0, rst_n = 0;
  logic [3:0] crit_req = 0;
  logic [16:0] main_req = 0;
  logic [31:0] per_req = 0, dma_req = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, enc_status;
  logic dma_valid;
  logic [4:0] dma_num;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  cascade_intc u_dut (.clk, .rst_n, .crit_req, .main_req, .per_req, .dma_req,
    .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .enc_status, .dma_valid, .dma_num);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); chk("R1 main mask", d, 32'h0001_0FFF);
    rd(1, d); chk("R1 per mask", d, 32'h7FFF_FC00);
    rd(2, d); chk("R1 dma mask", d, 32'hFFFF_FFFF);
    rd(3, d); chk("R1 pending", d, 0);
    chk("R1 R12 status idle", enc_status, 0);
  endtask

  task automatic t_crit();
    crit_req = 4'b1010; #1;
    chk("R9 R12 crit lowest", enc_status, 32'h0000_0500);
    crit_req = 4'b1000; #1;
    chk("R9 crit num3", enc_status, 32'h0000_0700);
    crit_req = 0; #1;
  endtask

  task automatic t_main();
    logic [31:0] d;
    main_req = 17'b1010; #1;
    chk("R10 R12 main lowest", enc_status, 32'h0021_0000);
    main_req = 17'h80; #1;
    chk("R3 main masked src7", enc_status, 0);
    wr(0, 32'h0001_0DFF); main_req = 17'h80; #1;
    chk("R4 main src7 unmasked", enc_status, 32'h0027_0000);
    main_req = 17'h82;
    wr(0, 32'h0001_8DFF); #1;
    chk("R4 main mask bit15 masks src1", enc_status, 32'h0027_0000);
    wr(0, 32'hFFFF_FFFF); rd(0, d);
    chk("R2 main mask width", d, 32'h0001_FFFF);
    main_req = 17'h10; wr(0, 32'h0001_0FFF); #1;
    chk("R10 main_req4 ignored", enc_status, 0);
    main_req = 0; #1;
  endtask

  task automatic t_per();
    per_req = 32'h0200_0000; #1;
    chk("R10 R11 per cascade", enc_status, 32'h3924_0000);
    per_req = 32'h0000_0020; #1;
    chk("R5 per src5 masked", enc_status, 0);
    wr(1, 32'h7BFF_FC00); per_req = 32'h0200_0021; #1;
    chk("R5 R12 per src5 wins, src0 ignored", enc_status, 32'h2524_0000);
    per_req = 0; wr(1, 32'h7FFF_FC00); #1;
  endtask

  task automatic t_dma();
    logic [31:0] d;
    wr(2, 32'hFFFF_FDF7);
    @(negedge clk); dma_req[9] = 1; settle();
    chk("R6 dma 9 latched", {dma_valid, 26'b0, dma_num}, {1'b1, 26'b0, 5'd9});
    chk("R11 status via dma", enc_status, 32'h2024_0000);
    dma_req[3] = 1; settle();
    chk("R11 R12 dma lowest", {27'b0, dma_num}, 3);
    rd(3, d); chk("R6 pending readback", d, 32'h0000_0208);
    rd(4, d); chk("R13 status read", d, enc_status);
    wr(3, 32'h8); rd(3, d); chk("R7 w1c clears bit3", d, 32'h200);
    wr(3, 0); rd(3, d); chk("R7 zero write keeps", d, 32'h200);
    wr(4, 32'hFFFF_FFFF); rd(3, d); chk("R7 status write ignored", d, 32'h200);
    wr(3, 32'h200); settle(); rd(3, d);
    chk("R6 held level no reset", d, 0);
    dma_req = 0; settle();
    dma_req[20] = 1; settle();
    rd(3, d); chk("R3 masked dma latched", d, 32'h0010_0000);
    chk("R3 masked dma no winner", {31'b0, dma_valid}, 0);
    wr(3, 32'hFFFF_FFFF); dma_req = 0; settle();
    @(negedge clk); reg_we = 1; reg_addr = 3; reg_wdata = 32'h8; dma_req[3] = 1;
    @(posedge clk); #1 reg_we = 0;
    rd(3, d); chk("R8 set beats clear", d, 32'h8);
    chk("R8 dma winner", {dma_valid, 26'b0, dma_num}, {1'b1, 26'b0, 5'd3});
    crit_req = 4'b0100; main_req = 17'h2; per_req = 32'h8000_0000; #1;
    chk("R9 R10 R11 all tiers", enc_status, 32'h2021_0600);
    crit_req = 0; main_req = 0; per_req = 0; dma_req = 0;
    wr(3, 32'hFFFF_FFFF); #1;
    chk("R12 all clear", enc_status, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    t_reset(); t_crit(); t_main(); t_per(); t_dma();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule